// File: doc/BRIEF.md
# Hardware Breakpoint Match Channel

This block is a single match channel of a debug break unit. Software programs a compare address, a per-bit don't-care mask and a control word. The channel then watches two kinds of processor activity. The first is instruction flow, seen as an issue strobe and a completion strobe from the core. The second is data-access cycles, tagged with the bus that carried them. When an enabled condition matches, the channel raises a one-cycle break request. A companion flag tells the core whether the request is a pre-execution break, which means the instruction now in the execute slot must be held back, or a post-execution break.

The channel watches one bus source at a time: the CPU bus or the internal DMA bus. Instruction strobes come only from the CPU side, so they count only while the CPU bus is selected. A pre-execution break is dropped in three cases: the instruction sits in a delay slot, a higher-priority exception claims the same instruction, or the module is in standby. A match on the second halfword of a 32-bit instruction in pre-execution mode is reported after that instruction completes. A sticky flag records every request, and software clears it by writing zero.

Top module: `brk_chan`

## Requirements
- R1: After a synchronous reset, all four registers read zero and `brk_req`, `brk_pre` and `reg_rdata` are low. The registers are address 0 (compare address), 1 (mask), 2 (control) and 3 (status, bit 0).
- R2: A write takes effect at the clock edge that ends its cycle. A match evaluated in the same cycle as the write uses the old value. A read issued in any later cycle returns the new value on `reg_rdata` one cycle after `reg_rd`, and `reg_rdata` is zero in every cycle that does not follow a read.
- R3: An address matches when it equals the compare address in every bit whose mask bit is 0. Mask bits set to 1 always match.
- R4: Control bit 0 selects the watched bus: 0 is the CPU bus, 1 is the DMA bus. Data cycles match only when `cyc_bus` equals that bit. Issue and completion strobes match only while the CPU bus is selected.
- R5: Control bit 2 enables instruction matches. Control bit 3 enables data matches. Bit 4 enables data reads and bit 5 enables data writes. A data match also requires the enable that fits `cyc_write`.
- R6: In pre-execution mode (control bit 1 = 0), an issue strobe whose address matches drives `brk_req` and `brk_pre` high for exactly the next cycle.
- R7: In post-execution mode (control bit 1 = 1), a completion strobe whose address matches, and any qualifying data cycle in either mode, drives `brk_req` high with `brk_pre` low for exactly the next cycle.
- R8: An issue strobe flagged as a delay-slot instruction never produces a pre-execution request.
- R9: In pre-execution mode, a completion strobe for a 32-bit instruction (`cmp_wide`) whose second-halfword address (`cmp_addr`+2) matches, while its first-halfword address does not, produces a post-execution request in the next cycle.
- R10: An issue or completion strobe that comes with its higher-priority-exception input produces no request.
- R11: While `standby` is high, no request is produced, register writes are ignored and `reg_rdata` stays zero.
- R12: Status bit 0 is set in the same cycle that `brk_req` rises. A status write with bit 0 = 0 clears it, a write with bit 0 = 1 leaves it unchanged, and setting wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Module standby: gates requests and register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, one cycle after `reg_rd` |
| iss_valid | input | 1 | Instruction about to execute |
| iss_addr | input | 32 | Address of the issuing instruction |
| iss_dslot | input | 1 | Issuing instruction is in a delay slot |
| iss_exc | input | 1 | Higher-priority exception on the issuing instruction |
| cmp_valid | input | 1 | Instruction completed |
| cmp_addr | input | 32 | First-halfword address of the completed instruction |
| cmp_wide | input | 1 | Completed instruction is 32 bits wide |
| cmp_exc | input | 1 | Higher-priority exception on the completed instruction |
| cyc_valid | input | 1 | Data access cycle present |
| cyc_bus | input | 1 | Bus of the data cycle: 0 CPU, 1 DMA |
| cyc_write | input | 1 | Data cycle is a write |
| cyc_addr | input | 32 | Data cycle address |
| brk_req | output | 1 | Break request, one-cycle pulse |
| brk_pre | output | 1 | Request is pre-execution; the core holds back the instruction |

## Verification
Each request is due in the cycle after the strobe that caused it. Read data is due in the cycle after `reg_rd`. A register write first shows its effect one cycle after the write strobe. The bench model advances at the same rising edge as the design, computes the expected `brk_req`, `brk_pre` and `reg_rdata` from register values held before that edge, and compares them at the following falling edge. Every cycle is therefore checked with exactly one register of latency. Directed sequences place a strobe in the same cycle as a write to show that the old value applies, and read back after standby and after status writes to show ignored and cleared state at the ports.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int REG_IDX_W = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_ADDR = 2'd0,
    RG_MASK = 2'd1,
    RG_CTRL = 2'd2,
    RG_STAT = 2'd3
  } reg_sel_e;

  // bit 0 dma_sel ... bit 5 wr_en
  typedef struct packed {
    logic wr_en;
    logic rd_en;
    logic data_en;
    logic fetch_en;
    logic post_mode;
    logic dma_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] probe,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] dont_care,
  output logic          hit
);
  always_comb hit = ~|((probe ^ ref_addr) & ~dont_care);
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 standby,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [AW-1:0]        wdata,
  input  logic                 set_flag,
  output logic [AW-1:0]        cmp_q,
  output logic [AW-1:0]        mask_q,
  output ctrl_t                ctl_q,
  output logic                 flag_q,
  output logic [AW-1:0]        rdata
);
  localparam int PAD_CTL = AW - CTRL_W;

  logic wr_ok;
  logic rd_ok;
  logic [AW-1:0] rd_mux;

  assign wr_ok = wr & ~standby;
  assign rd_ok = rd & ~standby;

  always_comb begin
    unique case (reg_sel_e'(idx))
      RG_ADDR: rd_mux = cmp_q;
      RG_MASK: rd_mux = mask_q;
      RG_CTRL: rd_mux = {{PAD_CTL{1'b0}}, ctl_q};
      default: rd_mux = {{(AW-1){1'b0}}, flag_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mask_q <= '0;
      ctl_q  <= '0;
      flag_q <= 1'b0;
      rdata  <= '0;
    end else begin
      rdata <= rd_ok ? rd_mux : '0;
      if (wr_ok && reg_sel_e'(idx) == RG_ADDR) cmp_q  <= wdata;
      if (wr_ok && reg_sel_e'(idx) == RG_MASK) mask_q <= wdata;
      if (wr_ok && reg_sel_e'(idx) == RG_CTRL) ctl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (set_flag)
        flag_q <= 1'b1;
      else if (wr_ok && reg_sel_e'(idx) == RG_STAT && !wdata[0])
        flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/brk_trig.sv
module brk_trig
  import brk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  standby,
  input  ctrl_t ctl,
  input  logic  iss_valid,
  input  logic  iss_dslot,
  input  logic  iss_exc,
  input  logic  iss_hit,
  input  logic  cmp_valid,
  input  logic  cmp_wide,
  input  logic  cmp_exc,
  input  logic  cmp_hit_hi,
  input  logic  cmp_hit_lo,
  input  logic  cyc_valid,
  input  logic  cyc_bus,
  input  logic  cyc_write,
  input  logic  cyc_hit,
  output logic  fire,
  output logic  brk_req,
  output logic  brk_pre
);
  logic ins_ok, pre_fire, post_ins, post_dat, dir_ok;

  assign ins_ok   = ~ctl.dma_sel & ctl.fetch_en & ~standby;
  assign pre_fire = ins_ok & iss_valid & iss_hit & ~ctl.post_mode
                  & ~iss_dslot & ~iss_exc;
  assign post_ins = ins_ok & cmp_valid & ~cmp_exc &
                    ( (ctl.post_mode & cmp_hit_hi)
                    | (~ctl.post_mode & cmp_wide & cmp_hit_lo & ~cmp_hit_hi));
  assign dir_ok   = cyc_write ? ctl.wr_en : ctl.rd_en;
  assign post_dat = ~standby & ctl.data_en & cyc_valid & cyc_hit & dir_ok
                  & (cyc_bus == ctl.dma_sel);
  assign fire     = pre_fire | post_ins | post_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req <= 1'b0;
      brk_pre <= 1'b0;
    end else begin
      brk_req <= fire;
      brk_pre <= pre_fire;
    end
  end
endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 standby,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_IDX_W-1:0] reg_addr,
  input  logic [AW-1:0]        reg_wdata,
  output logic [AW-1:0]        reg_rdata,
  input  logic                 iss_valid,
  input  logic [AW-1:0]        iss_addr,
  input  logic                 iss_dslot,
  input  logic                 iss_exc,
  input  logic                 cmp_valid,
  input  logic [AW-1:0]        cmp_addr,
  input  logic                 cmp_wide,
  input  logic                 cmp_exc,
  input  logic                 cyc_valid,
  input  logic                 cyc_bus,
  input  logic                 cyc_write,
  input  logic [AW-1:0]        cyc_addr,
  output logic                 brk_req,
  output logic                 brk_pre
);
  localparam int NPROBE = 4;
  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  logic [AW-1:0] cmp_q, mask_q;
  ctrl_t         ctl_q;
  logic          sts_q;
  logic          fire;
  logic [AW-1:0] probe [NPROBE];
  logic [NPROBE-1:0] hit;

  assign probe[0] = iss_addr;
  assign probe[1] = cmp_addr;
  assign probe[2] = cmp_addr + HALF_STEP;
  assign probe[3] = cyc_addr;

  for (genvar g = 0; g < NPROBE; g++) begin : g_cmp
    brk_addr_cmp #(.AW(AW)) cmp_i (
      .probe(probe[g]), .ref_addr(cmp_q), .dont_care(mask_q), .hit(hit[g])
    );
  end

  brk_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst(rst), .standby(standby),
    .wr(reg_wr), .rd(reg_rd), .idx(reg_addr), .wdata(reg_wdata),
    .set_flag(fire),
    .cmp_q(cmp_q), .mask_q(mask_q), .ctl_q(ctl_q), .flag_q(sts_q),
    .rdata(reg_rdata)
  );

  brk_trig trig_i (
    .clk(clk), .rst(rst), .standby(standby), .ctl(ctl_q),
    .iss_valid(iss_valid), .iss_dslot(iss_dslot), .iss_exc(iss_exc),
    .iss_hit(hit[0]),
    .cmp_valid(cmp_valid), .cmp_wide(cmp_wide), .cmp_exc(cmp_exc),
    .cmp_hit_hi(hit[1]), .cmp_hit_lo(hit[2]),
    .cyc_valid(cyc_valid), .cyc_bus(cyc_bus), .cyc_write(cyc_write),
    .cyc_hit(hit[3]),
    .fire(fire), .brk_req(brk_req), .brk_pre(brk_pre)
  );
endmodule

// File: rtl/brk_chan_chk.sv
module brk_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          standby,
  input logic          reg_rd,
  input logic [AW-1:0] reg_rdata,
  input logic          iss_valid,
  input logic          iss_dslot,
  input logic          iss_exc,
  input logic          cmp_valid,
  input logic          cyc_valid,
  input logic          brk_req,
  input logic          brk_pre,
  input logic          sts_q
);
  assert_standby_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    standby |=> !brk_req);

  assert_pre_is_req_R6: assert property (@(posedge clk) disable iff (rst)
    brk_pre |-> brk_req);

  assert_pre_from_issue_R6: assert property (@(posedge clk) disable iff (rst)
    brk_pre |-> $past(iss_valid));

  assert_dslot_no_break_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_dslot && !cmp_valid && !cyc_valid) |=> !brk_req);

  assert_exc_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_exc && !cmp_valid && !cyc_valid) |=> !brk_req);

  assert_flag_follows_req_R12: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> sts_q);

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_rd) |-> (reg_rdata == '0));
endmodule

bind brk_chan brk_chan_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .standby(standby), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .iss_valid(iss_valid), .iss_dslot(iss_dslot),
  .iss_exc(iss_exc), .cmp_valid(cmp_valid), .cyc_valid(cyc_valid),
  .brk_req(brk_req), .brk_pre(brk_pre), .sts_q(sts_q)
);

// File: tb/brk_chan_tb_top.sv
`timescale 1ns/1ps
module brk_chan_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic standby = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic iss_valid = 1'b0, iss_dslot = 1'b0, iss_exc = 1'b0;
  logic [31:0] iss_addr = '0;
  logic cmp_valid = 1'b0, cmp_wide = 1'b0, cmp_exc = 1'b0;
  logic [31:0] cmp_addr = '0;
  logic cyc_valid = 1'b0, cyc_bus = 1'b0, cyc_write = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic brk_req, brk_pre;

  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  brk_chan dut_i (.*);

  // behavioural reference model
  logic [31:0] m_cmp, m_mask, m_ctl;
  bit m_sts, e_req, e_pre;
  logic [31:0] e_rd;

  function automatic bit m_hit(logic [31:0] a);
    for (int b = 0; b < 32; b++)
      if (!m_mask[b] && a[b] !== m_cmp[b]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    bit pre, post, inst_on;
    logic [31:0] nxt;
    if (rst) begin
      m_cmp = 0; m_mask = 0; m_ctl = 0; m_sts = 0;
      e_req = 0; e_pre = 0; e_rd = 0;
    end else begin
      inst_on = !standby && !m_ctl[0] && m_ctl[2];
      pre = inst_on && iss_valid && !m_ctl[1] && !iss_dslot && !iss_exc
            && m_hit(iss_addr);
      post = 0;
      if (inst_on && cmp_valid && !cmp_exc) begin
        if (m_ctl[1] && m_hit(cmp_addr)) post = 1;
        if (!m_ctl[1] && cmp_wide && m_hit(cmp_addr + 2) && !m_hit(cmp_addr))
          post = 1;
      end
      if (!standby && m_ctl[3] && cyc_valid && cyc_bus == m_ctl[0] &&
          (cyc_write ? m_ctl[5] : m_ctl[4]) && m_hit(cyc_addr))
        post = 1;
      nxt = 0;
      if (reg_rd && !standby)
        case (reg_addr)
          0: nxt = m_cmp;
          1: nxt = m_mask;
          2: nxt = m_ctl;
          default: nxt = {31'b0, m_sts};
        endcase
      e_rd = nxt;
      e_req = pre || post;
      e_pre = pre;
      if (reg_wr && !standby)
        case (reg_addr)
          0: m_cmp = reg_wdata;
          1: m_mask = reg_wdata;
          2: m_ctl = {26'b0, reg_wdata[5:0]};
          default: if (!reg_wdata[0]) m_sts = 0;
        endcase
      if (e_req) m_sts = 1;
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (brk_req !== e_req || brk_pre !== e_pre || reg_rdata !== e_rd) begin
      n_bad++;
      $display("FAIL %s: req/pre/rdata got %b/%b/%h expected %b/%b/%h at %0t",
               cur_req, brk_req, brk_pre, reg_rdata, e_req, e_pre, e_rd, $time);
    end
  end

  task automatic clr();
    reg_wr = 0; reg_rd = 0; iss_valid = 0; iss_dslot = 0; iss_exc = 0;
    cmp_valid = 0; cmp_wide = 0; cmp_exc = 0; cyc_valid = 0;
    cyc_bus = 0; cyc_write = 0;
  endtask
  task automatic idle(int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask
  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); clr(); reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask
  task automatic rreg(logic [1:0] a);
    @(negedge clk); clr(); reg_rd = 1; reg_addr = a;
  endtask
  task automatic iss(logic [31:0] a, bit ds, bit ex);
    @(negedge clk); clr(); iss_valid = 1; iss_addr = a; iss_dslot = ds; iss_exc = ex;
  endtask
  task automatic done(logic [31:0] a, bit w, bit ex);
    @(negedge clk); clr(); cmp_valid = 1; cmp_addr = a; cmp_wide = w; cmp_exc = ex;
  endtask
  task automatic dcyc(logic [31:0] a, bit bus, bit wr);
    @(negedge clk); clr(); cyc_valid = 1; cyc_addr = a; cyc_bus = bus; cyc_write = wr;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_bad++;
      $display("FAIL watchdog: cycles %0d expected below 20000", cyc_cnt);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    for (int r = 0; r < 4; r++) rreg(2'(r));
    idle(2);
    cur_req = "R2";
    wreg(0, 32'h1000); rreg(0); wreg(2, 32'h04); rreg(2);
    @(negedge clk); clr(); reg_wr = 1; reg_addr = 0; reg_wdata = 32'h2000;
    iss_valid = 1; iss_addr = 32'h2000;
    iss(32'h2000, 0, 0); idle(2);
    cur_req = "R6";
    iss(32'h2000, 0, 0); iss(32'h2004, 0, 0); iss(32'h2000, 0, 0); idle(2);
    cur_req = "R3";
    wreg(1, 32'h0000_000F); iss(32'h200C, 0, 0); iss(32'h2010, 0, 0);
    iss(32'h3003, 0, 0); wreg(1, 0); idle(2);
    cur_req = "R8";
    iss(32'h2000, 1, 0); idle(1); iss(32'h2000, 0, 0); idle(2);
    cur_req = "R10";
    iss(32'h2000, 0, 1); idle(1);
    wreg(2, 32'h06); done(32'h2000, 0, 1); idle(2);
    cur_req = "R7";
    done(32'h2000, 0, 0); iss(32'h2000, 0, 0); done(32'h2002, 0, 0);
    done(32'h2000, 1, 0); idle(2);
    cur_req = "R9";
    wreg(2, 32'h04); wreg(0, 32'h2002);
    iss(32'h2000, 0, 0); done(32'h2000, 1, 0); done(32'h2000, 0, 0);
    done(32'h1FFE, 1, 0); iss(32'h2002, 0, 0); done(32'h2002, 1, 0); idle(2);
    cur_req = "R5";
    wreg(0, 32'h4000); wreg(2, 32'h18);
    dcyc(32'h4000, 0, 0); dcyc(32'h4000, 0, 1); iss(32'h4000, 0, 0);
    wreg(2, 32'h28); dcyc(32'h4000, 0, 0); dcyc(32'h4000, 0, 1);
    wreg(2, 32'h30); dcyc(32'h4000, 0, 0); idle(2);
    cur_req = "R4";
    wreg(2, 32'h3D); dcyc(32'h4000, 0, 0); dcyc(32'h4000, 1, 1);
    iss(32'h4000, 0, 0); done(32'h4000, 0, 0);
    wreg(2, 32'h3C); dcyc(32'h4000, 1, 0); dcyc(32'h4000, 0, 1); idle(2);
    cur_req = "R11";
    wreg(2, 32'h04);
    @(negedge clk); clr(); standby = 1;
    iss(32'h4000, 0, 0); dcyc(32'h4000, 0, 0); wreg(0, 32'h5000);
    rreg(0); idle(1);
    @(negedge clk); clr(); standby = 0;
    rreg(0); iss(32'h4000, 0, 0); idle(2);
    cur_req = "R12";
    rreg(3); wreg(3, 1); rreg(3); wreg(3, 0); rreg(3);
    @(negedge clk); clr(); reg_wr = 1; reg_addr = 3; reg_wdata = 0;
    iss_valid = 1; iss_addr = 32'h4000;
    rreg(3); idle(3);
    summary();
  end
endmodule